// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets a clocked system read and write one 8-bit word at a time in an external asynchronous static RAM with 15-bit addresses. A request carries a command bit, an address and write data. It is accepted through a valid/ready handshake. A read returns its byte on a one-cycle valid pulse. On the memory side the controller drives active-low chip-enable, write-enable and output-enable strobes and a held address. The data bus is split into an output value, a drive enable for the pad tri-state, and a sampled input value.

Each nanosecond rule of the memory is converted into a whole number of clock cycles when the block is elaborated. The conversion rounds the time up to a multiple of the clock period and never gives less than one cycle. After reset the block holds off all traffic for the power-up lockout. Writes are controlled by write-enable, and output-enable stays high while a write runs. The only bus turnaround to wait for is therefore the memory releasing the bus after output-enable rises at the end of a read. At the default 50 MHz clock, the lockout is 5000 cycles and every other window is one cycle.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and for at least 5000 cycles after reset is released (100 us at a 20 ns period), req_ready stays low, all three strobes stay high and sram_dq_oe stays low. req_ready then rises within 5003 cycles.
- R2: A read drives sram_ce_n and sram_oe_n low for exactly one cycle at the default timing, with sram_addr equal to the requested address. During that cycle sram_we_n stays high and sram_dq_oe stays low.
- R3: The byte on sram_dq_in is captured at the end of the read window. It is presented on rd_data while rd_valid is high for exactly one cycle, which is the cycle after the strobes rise.
- R4: After a read, both strobes stay high for one recovery cycle, the memory's output-disable time, before req_ready returns. sram_dq_oe never rises unless sram_oe_n was already high in the cycle before. A read keeps req_ready low for 2 cycles.
- R5: A write first holds sram_ce_n low and sram_we_n high for one address-setup cycle. It then holds sram_ce_n and sram_we_n both low for one cycle while sram_dq_out carries the write data. sram_oe_n stays high throughout, so write-enable and output-enable are never low together. sram_addr stays stable while sram_ce_n is low. A write keeps req_ready low for 3 cycles.
- R6: sram_dq_oe is high only while sram_we_n and sram_ce_n are both low. It falls in the same cycle in which sram_we_n rises.
- R7: req_ready is high only while no access is in progress, with all strobes high. A request presented while req_ready is low starts no memory access and is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read byte |
| rd_data | output | 8 | Captured read byte |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 15 | Memory address bus |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Tri-state drive enable for the data bus |
| sram_dq_in | input | 8 | Data sampled from the memory bus |

## Verification
The assertions check on every cycle the properties that involve only the strobes and the bus drive. These are: no ready before the lockout count, write-enable and output-enable never low together, bus drive only inside the write overlap and dropped as write-enable rises, the turnaround before any drive, a stable address under chip-enable, and a single-cycle read-valid pulse that follows a read window. Only the bench scenarios can show the exact number of cycles each strobe is low and the total busy time of each access type. They also show that the right byte lands at the right address and comes back on a later read, and that a request held during the lockout is really dropped.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_RD     = 3'd2,
    ST_RDREC  = 3'd3,
    ST_WSET   = 3'd4,
    ST_WPULSE = 3'd5,
    ST_WEND   = 3'd6
  } ctrl_state_e;

  // ceiling of ns / period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_pwr.sv
`timescale 1ns/1ps
module sram_ctrl_pwr #(
  parameter int unsigned LOCK_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(LOCK_CYC - 1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_ctrl_dwell.sv
`timescale 1ns/1ps
module sram_ctrl_dwell #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_PWRUP_NS    = 100000,
  parameter int unsigned T_RC_NS       = 10,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_DOE_NS      = 5,
  parameter int unsigned T_HZOE_NS     = 5,
  parameter int unsigned T_SA_NS       = 0,
  parameter int unsigned T_PWE_NS      = 7,
  parameter int unsigned T_SD_NS       = 5,
  parameter int unsigned T_AW_NS       = 7,
  parameter int unsigned T_HA_NS       = 0,
  parameter int unsigned T_WC_NS       = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  // cycle windows derived from the nanosecond rules
  localparam int unsigned PWR_CYC = ns_to_cyc(T_PWRUP_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC  = max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                    max2(ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_RC_NS, CLK_PERIOD_NS)));
  localparam int unsigned REC_CYC = ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int unsigned SET_CYC = ns_to_cyc(T_SA_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC  = max2(ns_to_cyc(T_PWE_NS, CLK_PERIOD_NS),
                                    max2(ns_to_cyc(T_SD_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)));
  localparam int unsigned HLD_0   = ns_to_cyc(T_HA_NS, CLK_PERIOD_NS);
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  // stretch the end phase so that the whole write meets the cycle minimum
  localparam int unsigned HLD_CYC = (SET_CYC + WP_CYC + HLD_0 >= WC_CYC) ? HLD_0
                                    : (WC_CYC - SET_CYC - WP_CYC);
  localparam int unsigned MAX_WIN = max2(max2(RD_CYC, REC_CYC),
                                    max2(max2(SET_CYC, WP_CYC), HLD_CYC));
  localparam int unsigned CW      = $clog2(MAX_WIN + 1);

  ctrl_state_e   state_q, state_d;
  logic          pwr_done;
  logic          win_zero;
  logic          win_load;
  logic [CW-1:0] win_val;
  logic          accept;
  logic          capture;

  sram_ctrl_pwr #(.LOCK_CYC(PWR_CYC)) u_pwr (
    .clk  (clk),
    .rst  (rst),
    .done (pwr_done)
  );

  sram_ctrl_dwell #(.CW(CW)) u_dwell (
    .clk      (clk),
    .rst      (rst),
    .load     (win_load),
    .load_val (win_val),
    .zero     (win_zero)
  );

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_PWRUP:  if (pwr_done) state_d = ST_IDLE;
      ST_IDLE:   if (req_valid && req_ready) begin
                   accept  = 1'b1;
                   state_d = req_write ? ST_WSET : ST_RD;
                 end
      ST_RD:     if (win_zero) begin
                   capture = 1'b1;
                   state_d = ST_RDREC;
                 end
      ST_RDREC:  if (win_zero) state_d = ST_IDLE;
      ST_WSET:   if (win_zero) state_d = ST_WPULSE;
      ST_WPULSE: if (win_zero) state_d = ST_WEND;
      ST_WEND:   if (win_zero) state_d = ST_IDLE;
      default:   state_d = ST_PWRUP;
    endcase
  end

  always_comb begin
    win_load = (state_d != state_q);
    unique case (state_d)
      ST_RD:     win_val = CW'(RD_CYC - 1);
      ST_RDREC:  win_val = CW'(REC_CYC - 1);
      ST_WSET:   win_val = CW'(SET_CYC - 1);
      ST_WPULSE: win_val = CW'(WP_CYC - 1);
      ST_WEND:   win_val = CW'(HLD_CYC - 1);
      default:   win_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_PWRUP;
      req_ready   <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      sram_ce_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
    end else begin
      state_q    <= state_d;
      req_ready  <= (state_d == ST_IDLE);
      sram_ce_n  <= !(state_d inside {ST_RD, ST_WSET, ST_WPULSE});
      sram_oe_n  <= (state_d != ST_RD);
      sram_we_n  <= (state_d != ST_WPULSE);
      sram_dq_oe <= (state_d == ST_WPULSE);
      rd_valid   <= capture;
      if (capture) rd_data <= sram_dq_in;
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_PWRUP_NS    = 100000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr
);
  localparam int unsigned LOCK = ns_to_cyc(T_PWRUP_NS, CLK_PERIOD_NS);
  localparam int unsigned CW   = $clog2(LOCK + 1);

  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(LOCK)) since_rst <= since_rst + 1'b1;
  end

  p_lockout_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (since_rst == CW'(LOCK)));

  p_lockout_strobes_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst != CW'(LOCK)) |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_rdv_source_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(!sram_oe_n) && $past(!sram_ce_n) && sram_oe_n));

  p_turnaround_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> ($past(sram_oe_n) && sram_oe_n));

  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!sram_we_n && !sram_oe_n));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  p_drive_window_r6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_we_n && !sram_ce_n));

  p_drive_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> !sram_dq_oe);

  p_ready_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_PWRUP_NS    (T_PWRUP_NS)
) u_sram_ctrl_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe),
  .sram_addr  (sram_addr)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [14:0] sram_addr;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  // behavioural memory and an independent expected copy
  logic [7:0] mem     [logic [14:0]];
  logic [7:0] ref_mem [logic [14:0]];

  function automatic logic [7:0] dflt(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [14:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return dflt(a);
  endfunction

  always_comb begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n)
      sram_dq_in = mem.exists(sram_addr) ? mem[sram_addr] : dflt(sram_addr);
    else
      sram_dq_in = 8'hEE;
  end

  always @(posedge clk)
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr] = sram_dq_out;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("[TB] FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int busy = 0, ce_c = 0, oe_c = 0, we_c = 0, dq_c = 0, rv_c = 0;
    bit bad_addr = 0, bad_data = 0;
    logic [7:0] got = 8'h00;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = $urandom() % 2; req_addr = 15'($urandom()); req_wdata = 8'($urandom());
    while (!req_ready && busy < 50) begin
      busy++;
      if (!sram_ce_n) begin ce_c++; if (sram_addr !== a) bad_addr = 1; end
      if (!sram_oe_n) oe_c++;
      if (!sram_we_n) we_c++;
      if (sram_dq_oe) begin dq_c++; if (sram_dq_out !== d) bad_data = 1; end
      if (rd_valid) begin rv_c++; got = rd_data; end
      @(negedge clk);
    end
    if (wr) begin
      chk(busy == 3, "R5 write busy cycles", busy, 3);
      chk(ce_c == 2 && we_c == 1 && oe_c == 0, "R5 write strobe cycles", ce_c*100 + we_c*10 + oe_c, 210);
      chk(!bad_data && !bad_addr, "R5 write addr/data", bad_data*2 + bad_addr, 0);
      chk(dq_c == 1 && rv_c == 0, "R6 drive cycles", dq_c, 1);
      ref_mem[a] = d;
    end else begin
      chk(busy == 2, "R4 read busy cycles", busy, 2);
      chk(ce_c == 1 && oe_c == 1 && we_c == 0 && dq_c == 0, "R2 read strobe cycles",
          ce_c*1000 + oe_c*100 + we_c*10 + dq_c, 1100);
      chk(!bad_addr, "R2 read address", bad_addr, 0);
      chk(rv_c == 1, "R3 rd_valid pulses", rv_c, 1);
      chk(got == exp_rd(a), "R3 read data", got, exp_rd(a));
    end
  endtask

  initial begin
    int pw;
    bit ce_seen;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    chk(!req_ready && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe,
        "R1 reset state", req_ready, 0);
    // request held through the whole lockout must be dropped
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h1234; req_wdata = 8'hAB;
    rst = 1'b0;
    pw = 0; ce_seen = 0;
    while (!req_ready && pw < 6000) begin
      @(negedge clk);
      pw++;
      if (!sram_ce_n || !sram_we_n || sram_dq_oe) ce_seen = 1;
    end
    req_valid = 1'b0;
    chk(pw >= 5000 && pw <= 5003, "R1 lockout length", pw, 5001);
    chk(!ce_seen, "R7 no access while not ready", ce_seen, 0);
    do_op(1'b0, 15'h1234, 8'h00);
    // directed corners
    do_op(1'b1, 15'h0000, 8'h00);
    do_op(1'b1, 15'h7FFF, 8'hFF);
    do_op(1'b0, 15'h0000, 8'h00);
    do_op(1'b0, 15'h7FFF, 8'h00);
    do_op(1'b1, 15'h0001, 8'hA5);
    do_op(1'b1, 15'h0001, 8'h5A);
    do_op(1'b0, 15'h0001, 8'h00);
    // random traffic on a small address window so reads hit written words
    for (int i = 0; i < 300; i++) begin
      logic [14:0] a;
      a = {7'($urandom() % 2 ? 7'h7F : 7'h00), 8'($urandom() % 16)};
      do_op(1'($urandom() % 2), a, 8'($urandom()));
      repeat ($urandom() % 3) @(negedge clk);
    end
    // readback of the whole window
    for (int i = 0; i < 16; i++) begin
      do_op(1'b0, {7'h00, 8'(i)}, 8'h00);
      do_op(1'b0, {7'h7F, 8'(i)}, 8'h00);
    end
    done = 1'b1;
    finish_run();
  end
endmodule